// File: doc/BRIEF.md
# Windowed Bus-to-PCI Address Translator

This block sits on the outgoing side of a bus-to-PCI bridge and turns internal-bus request addresses into PCI addresses. It holds four programmable windows. Windows 0, 1 and 2 map memory space and window 3 maps I/O space. Each window carries:

- an internal-bus base,
- a PCI base,
- a mask over address bits 28 to 8,
- an enable bit,
- a word-swap bit.

Bits 31 to 29 of a window always compare exactly, and the low byte of the address is never translated. A window therefore covers from 256 bytes up to 512 MB.

A request is one address qualified by a valid strobe. One clock later the block returns the result: a hit flag, the winning window, whether that window is I/O, the translated address and the window's swap attribute. Software programs the windows through a one-cycle write port. Each write names a window, a register selector and a 32-bit data word.

Top module: `pci_win_xlat`

## Requirements
- R1: After reset, every base, mask and attribute register holds zero and every window is disabled. `rsp_valid` is 0, and any request gives a miss.
- R2: A window matches only when request bits 31:29 equal its internal-bus base bits 31:29, whatever the mask holds.
- R3: Request bits 28:8 are compared with base bits 28:8 only where the mask bit is 0. Mask bits set to 1 exclude those positions from the compare.
- R4: On a hit, translated bits 31:29 are PCI base bits 31:29. Each translated bit in 28:8 comes from the PCI base where its mask bit is 0, and from the request where its mask bit is 1.
- R5: On a hit, translated bits 7:0 equal request bits 7:0.
- R6: When more than one enabled window matches, the lowest-numbered window wins.
- R7: A disabled window never matches, whatever its registers hold.
- R8: On a miss, `rsp_hit`, `rsp_io`, `rsp_swap`, `rsp_win` and `rsp_addr` are all zero.
- R9: `rsp_io` is 1 exactly when the winning window is window 3, the I/O window. Windows 0 to 2 report memory (`rsp_io` = 0).
- R10: `rsp_swap` reports the swap bit of the winning window.
- R11: `rsp_valid` is `req_valid` delayed by one clock. The result fields change only on a clock where `req_valid` was 1.
- R12: A register write takes effect for requests presented on a clock after the write. A request presented on the same clock as a write uses the old contents.
- R13: Write port encoding:
  - `wr_sel` = 0 writes the internal-bus base from `wr_data[31:8]`.
  - `wr_sel` = 1 writes the PCI base from `wr_data[31:8]`.
  - `wr_sel` = 2 writes the mask from `wr_data[28:8]`.
  - `wr_sel` = 3 writes enable from `wr_data[0]` and swap from `wr_data[1]`.
  - `wr_win` picks the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 2 | Window targeted by the write |
| wr_sel | input | 2 | Register selector (R13) |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Internal-bus request address |
| rsp_valid | output | 1 | Result valid, one clock after `req_valid` |
| rsp_hit | output | 1 | An enabled window matched |
| rsp_win | output | 2 | Index of the winning window |
| rsp_io | output | 1 | 1 when the winning window is I/O |
| rsp_swap | output | 1 | Swap attribute of the winning window |
| rsp_addr | output | 32 | Translated PCI address, zero on a miss |

## Verification
Every result field is due on the first rising edge after the edge that samples `req_valid`. The bench drives a request on a falling edge and drops it on the next falling edge. It compares all outputs at that second falling edge, half a period after the result register loads.

A register write becomes visible one edge after its strobe. The bench therefore places a request on the same clock as a write and expects the old mapping, then expects the new mapping on the next request. One more check confirms that `rsp_valid` falls on the clock after a cycle with no request.

// File: rtl/pci_win_xlat.sv
module pci_win_xlat #(
  parameter int NUM_WIN = 4,
  parameter int IO_WIN  = 3,
  localparam int WW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_win,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [WW-1:0] rsp_win,
  output logic          rsp_io,
  output logic          rsp_swap,
  output logic [31:0]   rsp_addr
);

  localparam int MW = 21;

  logic [23:0]        gbase [NUM_WIN];
  logic [23:0]        pbase [NUM_WIN];
  logic [MW-1:0]      mask  [NUM_WIN];
  logic [NUM_WIN-1:0] win_en;
  logic [NUM_WIN-1:0] win_swap;
  logic [NUM_WIN-1:0] match;

  logic          hit_c;
  logic [WW-1:0] sel_c;
  logic [31:0]   addr_c;

  logic unused_wr_bits;
  assign unused_wr_bits = &{1'b0, wr_data[7:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        gbase[i] <= '0;
        pbase[i] <= '0;
        mask[i]  <= '0;
      end
      win_en   <= '0;
      win_swap <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (wr_win == i[WW-1:0]) begin
          case (wr_sel)
            2'd0: gbase[i] <= wr_data[31:8];
            2'd1: pbase[i] <= wr_data[31:8];
            2'd2: mask[i]  <= wr_data[28:8];
            default: begin
              win_en[i]   <= wr_data[0];
              win_swap[i] <= wr_data[1];
            end
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign match[g] = win_en[g]
                    && (req_addr[31:29] == gbase[g][23:21])
                    && ((req_addr[28:8] & ~mask[g]) == (gbase[g][20:0] & ~mask[g]));
  end

  always_comb begin
    hit_c = 1'b0;
    sel_c = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_c = 1'b1;
        sel_c = i[WW-1:0];
      end
    end
  end

  assign addr_c = hit_c
    ? {pbase[sel_c][23:21],
       (pbase[sel_c][20:0] & ~mask[sel_c]) | (req_addr[28:8] & mask[sel_c]),
       req_addr[7:0]}
    : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
      rsp_io    <= 1'b0;
      rsp_swap  <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit  <= hit_c;
        rsp_win  <= sel_c;
        rsp_io   <= hit_c && (sel_c == IO_WIN[WW-1:0]);
        rsp_swap <= hit_c && win_swap[sel_c];
        rsp_addr <= addr_c;
      end
    end
  end

endmodule

// File: rtl/pci_win_xlat_chk.sv
module pci_win_xlat_chk #(
  parameter int NUM_WIN = 4,
  parameter int IO_WIN  = 3,
  localparam int WW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [31:0]        req_addr,
  input logic [NUM_WIN-1:0] win_en,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [WW-1:0]      rsp_win,
  input logic               rsp_io,
  input logic               rsp_swap,
  input logic [31:0]        rsp_addr
);

  // R11
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == 32'h0 && !rsp_io && !rsp_swap && rsp_win == '0));

  // R9
  io_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_io == (rsp_win == IO_WIN[WW-1:0])));

  // R5
  low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_addr[7:0] == $past(req_addr[7:0])));

  // R7
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || ((($past(win_en) >> rsp_win) & 1) != 0)));

endmodule

bind pci_win_xlat pci_win_xlat_chk #(.NUM_WIN(NUM_WIN), .IO_WIN(IO_WIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .win_en(win_en), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
  .rsp_io(rsp_io), .rsp_swap(rsp_swap), .rsp_addr(rsp_addr)
);

// File: tb/pci_win_xlat_tb.sv
`timescale 1ns/1ps
module pci_win_xlat_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_win = '0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_io, rsp_swap;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pci_win_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
    .wr_data(wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_io(rsp_io),
    .rsp_swap(rsp_swap), .rsp_addr(rsp_addr)
  );

  localparam int NV = 10;
  localparam logic [31:0] V_IN [NV] = '{
    32'h2012_3456, 32'h2512_3456, 32'h3012_3456, 32'hA012_3456, 32'h4000_00FF,
    32'h4000_01FF, 32'h6001_2ABC, 32'h6001_3ABC, 32'h2FFF_FFFF, 32'h2000_0000};
  localparam logic [31:0] V_OUT [NV] = '{
    32'h8012_3456, 32'hB512_3456, 32'h0,         32'h0,         32'h0000_00FF,
    32'h0,         32'h0000_1ABC, 32'h0,         32'hBFFF_FFFF, 32'h8000_0000};
  // {hit, win[1:0], io, swap}
  localparam logic [4:0] V_FLG [NV] = '{
    5'b1_00_0_0, 5'b1_01_0_1, 5'b0_00_0_0, 5'b0_00_0_0, 5'b1_10_0_1,
    5'b0_00_0_0, 5'b1_11_1_0, 5'b0_00_0_0, 5'b1_01_0_1, 5'b1_00_0_0};
  localparam string V_REQ [NV] = '{
    "R6", "R4", "R3", "R2", "R10", "R3", "R9", "R3", "R4", "R5"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = w; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic req_chk(input string req, input logic [31:0] a,
                         input logic [31:0] ea, input logic [4:0] ef);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, {31'h0, rsp_valid}, 32'h1);
    check(req, {27'h0, rsp_hit, rsp_win, rsp_io, rsp_swap}, {27'h0, ef});
    check(req, rsp_addr, ea);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    req_chk("R1", 32'h0000_0000, 32'h0, 5'b0);
    req_chk("R1", 32'h2012_3456, 32'h0, 5'b0);

    // R13 window programming
    wr(2'd0, 2'd0, 32'h2000_0000); wr(2'd0, 2'd1, 32'h8000_0000);
    wr(2'd0, 2'd2, 32'h00FF_FF00); wr(2'd0, 2'd3, 32'h1);
    wr(2'd1, 2'd0, 32'h2000_0000); wr(2'd1, 2'd1, 32'hB000_0000);
    wr(2'd1, 2'd2, 32'h0FFF_FF00); wr(2'd1, 2'd3, 32'h3);
    wr(2'd2, 2'd0, 32'h4000_0000); wr(2'd2, 2'd1, 32'h0000_0000);
    wr(2'd2, 2'd2, 32'h0);         wr(2'd2, 2'd3, 32'h3);
    wr(2'd3, 2'd0, 32'h6001_2300); wr(2'd3, 2'd1, 32'h0000_1000);
    wr(2'd3, 2'd2, 32'h0000_0F00); wr(2'd3, 2'd3, 32'h1);

    for (int i = 0; i < NV; i++) req_chk(V_REQ[i], V_IN[i], V_OUT[i], V_FLG[i]);

    // R7: disable window 0, overlapping window 1 takes over
    wr(2'd0, 2'd3, 32'h0);
    req_chk("R7", 32'h2012_3456, 32'hB012_3456, 5'b1_01_0_1);

    // R12: write on same clock as request sees old contents
    @(negedge clk);
    wr_en = 1'b1; wr_win = 2'd0; wr_sel = 2'd3; wr_data = 32'h1;
    req_valid = 1'b1; req_addr = 32'h2012_3456;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R12", rsp_addr, 32'hB012_3456);
    check("R12", {31'h0, rsp_swap}, 32'h1);
    req_chk("R12", 32'h2012_3456, 32'h8012_3456, 5'b1_00_0_0);

    // R11: no request, valid drops and fields hold
    @(negedge clk);
    check("R11", {31'h0, rsp_valid}, 32'h0);
    check("R11", rsp_addr, 32'h8012_3456);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule